// File: doc/BRIEF.md
# Servo Channel Frame Packer

This block builds the 13-byte payload that a frequency-hopping control transmitter sends on each hop. On a build strobe it takes a snapshot of eight raw stick and auxiliary values, the 16-bit transmitter identity, the current hop channel index, the hop code and a packet state code. The state code picks which four of the eight channels go into the frame. Each of those four channels is clamped and then scaled linearly onto a 10-bit servo range. The block packs every field into a fixed bit layout, in which channel values cross byte boundaries and are separated by constant two-bit spacer patterns.

The finished frame is held in a register and sent out one byte per handshake on a valid/ready stream. A flag marks the final byte. The radio that receives this stream adds its own preamble, sync word and CRC.

Top module: `servo_frame_packer`

## Requirements
- R1: After reset, `outValid` is low and `outLast` is low.
- R2: A `buildStb` pulse while `outValid` is low raises `outValid` on the next clock. The first byte presented is 0x81.
- R3: Byte 0 is 0x81. Byte 1 is `txId[15:8]`, byte 2 is `txId[7:0]`, and bytes 3 and 4 are 0x00.
- R4: Each carried channel value c is 86 + (min(raw, 2047) × 820) / 2047, with the division truncated. Raw 0 gives 86, raw 1024 gives 496, and any raw value of 2047 or more gives 906.
- R5: With `stateCode` equal to 0x02, slots c1..c4 carry raw channels 0..3. With any other state code they carry raw channels 4..7. Raw channel k sits at `rawChans[16k+15:16k]`.
- R6: The channel bytes are laid out as follows, with every bit position counted from the MSB at bit 7:
  - Byte 5 = {hopIdx[4:0], 2'b10, c1[9]}
  - Byte 6 = c1[8:1]
  - Byte 7 = {c1[0], 2'b10, c2[9:5]}
  - Byte 8 = {c2[4:0], 2'b10, c3[9]}
  - Byte 9 = c3[8:1]
  - Byte 10 = {c3[0], 2'b10, c4[9:5]}
- R7: Byte 11 = {c4[4:0], hopCode[4:2]} and byte 12 = {hopCode[1:0], stateCode[5:0]}.
- R8: While `outValid` is high and `outReady` is low, `outData` and `outLast` keep their values on the next clock.
- R9: `outLast` is high only while byte 12 is presented. After byte 12 is accepted, `outValid` falls on the next clock.
- R10: A `buildStb` while a frame is being sent is ignored. The bytes of the current frame do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| buildStb | input | 1 | Snapshot the inputs and start a frame |
| rawChans | input | 128 | Eight raw channel values, 16 bits each, channel 0 in the low bits |
| txId | input | 16 | Transmitter identity |
| hopIdx | input | 5 | Current hop channel index |
| hopCode | input | 5 | Hop sequence code |
| stateCode | input | 6 | Packet state code (0x02 or 0x0B) |
| outData | output | 8 | Current frame byte |
| outValid | output | 1 | A frame byte is presented |
| outReady | input | 1 | Consumer accepts the byte this cycle |
| outLast | output | 1 | The presented byte is byte 12 |

## Verification
The assertions assume that the consumer drives `outReady` as a plain level that it may drop at any time. They also assume that `buildStb` can arrive in any cycle, including in the middle of a frame. The stimulus draws `outReady` at random with frequent stalls and pulses `buildStb` in the middle of a frame with altered inputs. It also covers raw values above the 2047 limit and uses both state codes.

// File: rtl/frame_pkg.sv
package frame_pkg;
  localparam int FRAME_BYTES = 13;
  localparam int IDX_W = $clog2(FRAME_BYTES);
  localparam logic [7:0] HEAD_BYTE = 8'h81;
  localparam logic [1:0] SPACER = 2'b10;

  typedef struct packed {
    logic load;
    logic [IDX_W-1:0] byteIdx;
  } pack_ctrl_t;

  typedef enum logic {ST_IDLE, ST_SEND} send_state_t;
endpackage

// File: rtl/chan_scale.sv
module chan_scale #(
  parameter int RAW_W = 16,
  parameter int RAW_MAX = 2047,
  parameter int OUT_MIN = 86,
  parameter int OUT_MAX = 906,
  parameter int OUT_W = 10
) (
  input  logic [RAW_W-1:0] rawVal,
  output logic [OUT_W-1:0] scaled
);
  localparam int SPAN = OUT_MAX - OUT_MIN;
  localparam int CLAMP_W = $clog2(RAW_MAX + 1);
  localparam int PROD_W = CLAMP_W + $clog2(SPAN + 1);

  logic [CLAMP_W-1:0] clamped;
  logic [PROD_W-1:0] prod;
  logic [PROD_W-1:0] quot;

  always_comb begin
    if (rawVal > RAW_W'(RAW_MAX)) clamped = CLAMP_W'(RAW_MAX);
    else clamped = rawVal[CLAMP_W-1:0];
    prod = PROD_W'(clamped) * PROD_W'(SPAN);
    quot = prod / PROD_W'(RAW_MAX);
    scaled = OUT_W'(quot) + OUT_W'(OUT_MIN);
  end
endmodule

// File: rtl/frame_datapath.sv
module frame_datapath
  import frame_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int RAW_W = 16,
  parameter int ID_W = 16,
  parameter int HOP_W = 5,
  parameter int STATE_W = 6,
  parameter logic [STATE_W-1:0] FIRST_HALF_CODE = 6'h02
) (
  input  logic clk,
  input  logic rstN,
  input  pack_ctrl_t ctrl,
  input  logic [NUM_CH*RAW_W-1:0] rawChans,
  input  logic [ID_W-1:0] txId,
  input  logic [HOP_W-1:0] hopIdx,
  input  logic [HOP_W-1:0] hopCode,
  input  logic [STATE_W-1:0] stateCode,
  output logic [7:0] byteOut
);
  localparam int SLOTS = NUM_CH / 2;
  localparam int VAL_W = 10;

  logic upperHalf;
  logic [VAL_W-1:0] slotVal [SLOTS];
  logic [7:0] frameD [0:FRAME_BYTES-1];
  logic [7:0] frameQ [0:FRAME_BYTES-1];

  assign upperHalf = (stateCode != FIRST_HALF_CODE);

  for (genvar k = 0; k < SLOTS; k++) begin : g_slot
    logic [RAW_W-1:0] pick;
    assign pick = upperHalf ? rawChans[(k+SLOTS)*RAW_W +: RAW_W]
                            : rawChans[k*RAW_W +: RAW_W];
    chan_scale #(.RAW_W(RAW_W), .OUT_W(VAL_W)) u_scale (
      .rawVal(pick),
      .scaled(slotVal[k])
    );
  end

  always_comb begin
    frameD[0]  = HEAD_BYTE;
    frameD[1]  = txId[15:8];
    frameD[2]  = txId[7:0];
    frameD[3]  = 8'h00;
    frameD[4]  = 8'h00;
    frameD[5]  = {hopIdx[4:0], SPACER, slotVal[0][9]};
    frameD[6]  = slotVal[0][8:1];
    frameD[7]  = {slotVal[0][0], SPACER, slotVal[1][9:5]};
    frameD[8]  = {slotVal[1][4:0], SPACER, slotVal[2][9]};
    frameD[9]  = slotVal[2][8:1];
    frameD[10] = {slotVal[2][0], SPACER, slotVal[3][9:5]};
    frameD[11] = {slotVal[3][4:0], hopCode[4:2]};
    frameD[12] = {hopCode[1:0], stateCode[5:0]};
  end

  for (genvar b = 0; b < FRAME_BYTES; b++) begin : g_byte
    always_ff @(posedge clk) begin
      if (!rstN) frameQ[b] <= 8'h00;
      else if (ctrl.load) frameQ[b] <= frameD[b];
    end
  end

  always_comb begin
    byteOut = 8'h00;
    for (int b = 0; b < FRAME_BYTES; b++)
      if (ctrl.byteIdx == IDX_W'(b)) byteOut = frameQ[b];
  end
endmodule

// File: rtl/frame_ctrl.sv
module frame_ctrl
  import frame_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic buildStb,
  input  logic outReady,
  output logic outValid,
  output logic outLast,
  output pack_ctrl_t ctrl
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_BYTES - 1);

  send_state_t state;
  logic [IDX_W-1:0] idx;

  always_comb begin
    ctrl.load = (state == ST_IDLE) && buildStb;
    ctrl.byteIdx = idx;
    outValid = (state == ST_SEND);
    outLast = (state == ST_SEND) && (idx == LAST_IDX);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      idx <= '0;
    end else begin
      case (state)
        ST_IDLE: if (buildStb) begin
          state <= ST_SEND;
          idx <= '0;
        end
        ST_SEND: if (outReady) begin
          if (idx == LAST_IDX) begin
            state <= ST_IDLE;
            idx <= '0;
          end else begin
            idx <= idx + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/servo_frame_packer.sv
module servo_frame_packer
  import frame_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int RAW_W = 16,
  parameter int ID_W = 16,
  parameter int HOP_W = 5,
  parameter int STATE_W = 6
) (
  input  logic clk,
  input  logic rstN,
  input  logic buildStb,
  input  logic [NUM_CH*RAW_W-1:0] rawChans,
  input  logic [ID_W-1:0] txId,
  input  logic [HOP_W-1:0] hopIdx,
  input  logic [HOP_W-1:0] hopCode,
  input  logic [STATE_W-1:0] stateCode,
  output logic [7:0] outData,
  output logic outValid,
  input  logic outReady,
  output logic outLast
);
  pack_ctrl_t ctrl;

  frame_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .buildStb(buildStb), .outReady(outReady),
    .outValid(outValid), .outLast(outLast), .ctrl(ctrl)
  );

  frame_datapath #(
    .NUM_CH(NUM_CH), .RAW_W(RAW_W), .ID_W(ID_W),
    .HOP_W(HOP_W), .STATE_W(STATE_W)
  ) u_data (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .rawChans(rawChans), .txId(txId),
    .hopIdx(hopIdx), .hopCode(hopCode), .stateCode(stateCode),
    .byteOut(outData)
  );
endmodule

// File: rtl/servo_frame_packer_chk.sv
module servo_frame_packer_chk (
  input logic clk,
  input logic rstN,
  input logic buildStb,
  input logic [7:0] outData,
  input logic outValid,
  input logic outReady,
  input logic outLast
);
  logic [3:0] seen;

  always_ff @(posedge clk) begin
    if (!rstN) seen <= '0;
    else if (outValid && outReady) seen <= outLast ? 4'd0 : seen + 4'd1;
  end

  p_reset_idle_r1: assert property (@(posedge clk)
    $rose(rstN) |-> !outValid && !outLast);

  p_build_start_r2: assert property (@(posedge clk) disable iff (!rstN)
    !outValid && buildStb |=> outValid);

  p_head_byte_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(outValid) |-> outData == 8'h81);

  p_hold_stall_r8: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outReady |=> outValid && $stable(outData) && $stable(outLast));

  p_last_pos_r9: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (outLast == (seen == 4'd12)));

  p_last_drop_r9: assert property (@(posedge clk) disable iff (!rstN)
    outValid && outReady && outLast |=> !outValid);

  p_last_valid_r9: assert property (@(posedge clk) disable iff (!rstN)
    outLast |-> outValid);
endmodule

bind servo_frame_packer servo_frame_packer_chk u_chk (
  .clk(clk), .rstN(rstN), .buildStb(buildStb), .outData(outData),
  .outValid(outValid), .outReady(outReady), .outLast(outLast)
);

// File: tb/sim_servo_frame_packer.sv
`timescale 1ns/1ps
module sim_servo_frame_packer;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic buildStb = 1'b0;
  logic [127:0] rawChans;
  logic [15:0] rawTb [8];
  logic [15:0] txId = '0;
  logic [4:0] hopIdx = '0;
  logic [4:0] hopCode = '0;
  logic [5:0] stateCode = 6'h02;
  logic [7:0] outData;
  logic outValid, outReady = 1'b0, outLast;

  int total = 0;
  int bad = 0;
  logic [7:0] expB [13];

  always #5 clk = ~clk;

  always_comb
    for (int k = 0; k < 8; k++) rawChans[k*16 +: 16] = rawTb[k];

  servo_frame_packer u0 (
    .clk(clk), .rstN(rstN), .buildStb(buildStb), .rawChans(rawChans),
    .txId(txId), .hopIdx(hopIdx), .hopCode(hopCode), .stateCode(stateCode),
    .outData(outData), .outValid(outValid), .outReady(outReady),
    .outLast(outLast)
  );

  task automatic check(input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [9:0] expScale(input logic [15:0] v);
    int vv;
    vv = (v > 16'd2047) ? 2047 : int'(v);
    return 10'(86 + (vv * 820) / 2047);
  endfunction

  task automatic computeExp();
    logic [9:0] c [4];
    int base;
    base = (stateCode == 6'h02) ? 0 : 4;
    for (int k = 0; k < 4; k++) c[k] = expScale(rawTb[base + k]);
    expB[0] = 8'h81; expB[1] = txId[15:8]; expB[2] = txId[7:0];
    expB[3] = 8'h00; expB[4] = 8'h00;
    expB[5] = {hopIdx, 2'b10, c[0][9]};
    expB[6] = c[0][8:1];
    expB[7] = {c[0][0], 2'b10, c[1][9:5]};
    expB[8] = {c[1][4:0], 2'b10, c[2][9]};
    expB[9] = c[2][8:1];
    expB[10] = {c[2][0], 2'b10, c[3][9:5]};
    expB[11] = {c[3][4:0], hopCode[4:2]};
    expB[12] = {hopCode[1:0], stateCode};
  endtask

  task automatic runFrame(input string chTag, input bit inject);
    int n = 0;
    int guard = 0;
    logic prevStall = 1'b0;
    logic [7:0] prevData = '0;
    @(negedge clk);
    buildStb = 1'b1;
    computeExp();
    @(negedge clk);
    buildStb = 1'b0;
    check("R2 valid", 32'(outValid), 32'd1);
    check("R2 first", 32'(outData), 32'h81);
    while (n < 13 && guard < 1000) begin
      guard++;
      if (prevStall) check("R8 hold", 32'(outData), 32'(prevData));
      if (inject && n == 3 && guard < 20) begin
        outReady = 1'b0;
        buildStb = 1'b1;
        for (int k = 0; k < 8; k++) rawTb[k] = 16'($urandom);
        txId = ~txId;
        stateCode = (stateCode == 6'h02) ? 6'h0B : 6'h02;
      end else begin
        buildStb = 1'b0;
        outReady = ($urandom % 3) != 0;
      end
      if (outValid && outReady) begin
        if (n < 5) check("R3 byte", 32'(outData), 32'(expB[n]));
        else if (n > 10) check("R7 byte", 32'(outData), 32'(expB[n]));
        else check(chTag, 32'(outData), 32'(expB[n]));
        check("R9 last", 32'(outLast), (n == 12) ? 32'd1 : 32'd0);
        n++;
      end
      prevStall = outValid && !outReady;
      prevData = outData;
      @(negedge clk);
    end
    buildStb = 1'b0;
    outReady = 1'b0;
    check("R9 drop", 32'(outValid), 32'd0);
  endtask

  initial begin
    #1_500_000;
    bad++;
    total++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    for (int k = 0; k < 8; k++) rawTb[k] = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 valid", 32'(outValid), 32'd0);
    check("R1 last", 32'(outLast), 32'd0);

    txId = 16'hBC11; hopIdx = 5'd0; hopCode = 5'd0; stateCode = 6'h02;
    runFrame("R4 zero", 1'b0);

    for (int k = 0; k < 8; k++) rawTb[k] = (k % 2) ? 16'hFFFF : 16'd2047;
    hopIdx = 5'd31; hopCode = 5'd27; stateCode = 6'h0B;
    runFrame("R4 top", 1'b0);

    rawTb[0] = 16'd1024; rawTb[1] = 16'd1023; rawTb[2] = 16'd1;
    rawTb[3] = 16'd2048;
    stateCode = 6'h02;
    runFrame("R4 mid", 1'b0);

    for (int k = 0; k < 8; k++) rawTb[k] = 16'(k * 250);
    stateCode = 6'h02; hopIdx = 5'd13;
    runFrame("R5 low", 1'b0);
    stateCode = 6'h0B;
    runFrame("R5 high", 1'b0);

    txId = 16'h5A3C; stateCode = 6'h02; hopCode = 5'd21;
    runFrame("R10 inject", 1'b1);

    for (int t = 0; t < 25; t++) begin
      for (int k = 0; k < 8; k++) rawTb[k] = 16'($urandom % 2400);
      txId = 16'($urandom);
      hopIdx = 5'($urandom % 30);
      hopCode = 5'($urandom % 28);
      stateCode = ($urandom % 2) ? 6'h0B : 6'h02;
      runFrame("R6 rand", 1'b0);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule